// File: doc/BRIEF.md
# Gated Three-Bit Line Selector

This block turns a three-bit select code into one of eight active-low select lines. It is typically used as an address decoder, where each output line picks one of eight devices or banks. The block has no clock and no state. Its outputs follow the inputs within the same time step.

Three enable inputs qualify the selection. One enable is asserted high and the other two are asserted low. All three must be asserted at the same time before any line can go active. Otherwise every line rests high, whatever the select code is.

Inside the block, an active-high one-hot vector is formed from the combined enable and each select minterm. That vector is then inverted to drive the pins.

Top module: `gated_line_sel`

## Requirements
- R1: With `en_hi_i` low, all eight bits of `line_n_o` are 1, whatever the other inputs are.
- R2: With `en_lo_a_n_i` high or `en_lo_b_n_i` high, all eight bits of `line_n_o` are 1.
- R3: With `en_hi_i`=1, `en_lo_a_n_i`=0 and `en_lo_b_n_i`=0, exactly one bit of `line_n_o` is 0.
- R4: When enabled, the bit driven to 0 is `line_n_o[k]`, where k = 4*`sel_i[2]` + 2*`sel_i[1]` + `sel_i[0]`. Bit 2 of `sel_i` is the most significant.
- R5: While disabled, changing `sel_i` leaves `line_n_o` at 8'hFF.
- R6: The outputs are active-low. A selected line reads 0 and an idle line reads 1.
- R7: The block is purely combinational. Outputs settle to the new value in the same time step as an input change, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_i | input | 3 | Select code; bit 2 is the most significant |
| en_hi_i | input | 1 | Enable, asserted high |
| en_lo_a_n_i | input | 1 | First enable, asserted low |
| en_lo_b_n_i | input | 1 | Second enable, asserted low |
| line_n_o | output | 8 | Active-low one-hot select lines |

## Verification
Enable qualification and select decoding act on the same input change. The risky case is when an enable edge and a select change land together.

The bench provokes this by changing an enable and `sel_i` in the same step. It sweeps all 64 combinations of enables and select, so every enable transition pairs with a select change. After each step it compares `line_n_o` with the model: eight ones when any enable is deasserted, and a single zero at the select index otherwise.

// File: rtl/gated_line_sel_pkg.sv
package gated_line_sel_pkg;
    localparam int unsigned SEL_W = 3;
    localparam int unsigned OUT_W = 1 << SEL_W;

    typedef struct packed {
        logic hi;
        logic lo_a_n;
        logic lo_b_n;
    } enables_t;
endpackage

// File: rtl/gls_enable_qual.sv
module gls_enable_qual
    import gated_line_sel_pkg::*;
(
    input  enables_t en_i,
    output logic     en_ok_o
);
    logic en_ok_d;

    always_comb begin
        en_ok_d = en_i.hi & ~en_i.lo_a_n & ~en_i.lo_b_n;
        en_ok_o = en_ok_d;
    end
endmodule

// File: rtl/gls_minterm.sv
module gls_minterm
    import gated_line_sel_pkg::*;
#(
    parameter int unsigned SW = SEL_W,
    localparam int unsigned OW = 1 << SW
) (
    input  logic [SW-1:0] sel_i,
    input  logic          en_ok_i,
    output logic [OW-1:0] hot_o
);
    for (genvar k = 0; k < OW; k++) begin : g_term
        assign hot_o[k] = en_ok_i & (sel_i == SW'(k));
    end

    always_comb begin
        // R3
        hot_single_chk: assert ($onehot0(hot_o));
    end
endmodule

// File: rtl/gls_polarity.sv
module gls_polarity #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] hot_i,
    output logic [W-1:0] line_n_o
);
    logic [W-1:0] line_n_d;

    always_comb begin
        line_n_d = ~hot_i;
        line_n_o = line_n_d;
    end
endmodule

// File: rtl/gated_line_sel.sv
module gated_line_sel
    import gated_line_sel_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    input  logic             en_hi_i,
    input  logic             en_lo_a_n_i,
    input  logic             en_lo_b_n_i,
    output logic [OUT_W-1:0] line_n_o
);
    enables_t         en_d;
    logic             en_ok;
    logic [OUT_W-1:0] hot;

    always_comb begin
        en_d.hi     = en_hi_i;
        en_d.lo_a_n = en_lo_a_n_i;
        en_d.lo_b_n = en_lo_b_n_i;
    end

    gls_enable_qual i_qual (
        .en_i    (en_d),
        .en_ok_o (en_ok)
    );

    gls_minterm #(.SW(SEL_W)) i_term (
        .sel_i   (sel_i),
        .en_ok_i (en_ok),
        .hot_o   (hot)
    );

    gls_polarity #(.W(OUT_W)) i_pol (
        .hot_i    (hot),
        .line_n_o (line_n_o)
    );

    always_comb begin
        // R1
        hi_off_idle_chk: assert (en_hi_i || line_n_o == '1);
        // R2
        lo_off_idle_chk: assert (!(en_lo_a_n_i || en_lo_b_n_i) || line_n_o == '1);
        // R3
        one_low_chk: assert (!en_ok || $countones(~line_n_o) == 1);
        // R4
        index_low_chk: assert (!en_ok || line_n_o[sel_i] == 1'b0);
    end
endmodule

// File: tb/test_gated_line_sel.sv
module test_gated_line_sel;
    localparam int CLK_PERIOD = 10;
    localparam int N_DIR = 12;
    localparam logic [13:0] DIR_VEC [N_DIR] = '{
        {1'b1, 1'b0, 1'b0, 3'd0, 8'hFE},
        {1'b1, 1'b0, 1'b0, 3'd1, 8'hFD},
        {1'b1, 1'b0, 1'b0, 3'd2, 8'hFB},
        {1'b1, 1'b0, 1'b0, 3'd3, 8'hF7},
        {1'b1, 1'b0, 1'b0, 3'd4, 8'hEF},
        {1'b1, 1'b0, 1'b0, 3'd5, 8'hDF},
        {1'b1, 1'b0, 1'b0, 3'd6, 8'hBF},
        {1'b1, 1'b0, 1'b0, 3'd7, 8'h7F},
        {1'b0, 1'b0, 1'b0, 3'd5, 8'hFF},
        {1'b1, 1'b1, 1'b0, 3'd2, 8'hFF},
        {1'b1, 1'b0, 1'b1, 3'd6, 8'hFF},
        {1'b0, 1'b1, 1'b1, 3'd0, 8'hFF}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel;
    logic       en_hi, en_a_n, en_b_n;
    logic [7:0] line_n;
    int         n_chk = 0;
    int         n_bad = 0;
    int         cyc = 0;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gated_line_sel i_gated_line_sel (
        .sel_i       (sel),
        .en_hi_i     (en_hi),
        .en_lo_a_n_i (en_a_n),
        .en_lo_b_n_i (en_b_n),
        .line_n_o    (line_n)
    );

    function automatic logic [7:0] model(logic h, logic a, logic b, logic [2:0] s);
        if (h && !a && !b) return ~(8'b1 << s);
        return 8'hFF;
    endfunction

    task automatic apply(logic h, logic a, logic b, logic [2:0] s);
        en_hi = h; en_a_n = a; en_b_n = b; sel = s;
        #1;
    endtask

    task automatic check(string req, logic [7:0] exp);
        n_chk++;
        if (line_n !== exp) begin
            n_bad++;
            $display("FAIL %s: en=%b%b%b sel=%0d got %h expected %h",
                     req, en_hi, en_a_n, en_b_n, sel, line_n, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        apply(1'b0, 1'b1, 1'b1, 3'd0);
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset idle", 8'hFF);

        for (int i = 0; i < N_DIR; i++) begin
            @(negedge clk);
            apply(DIR_VEC[i][13], DIR_VEC[i][12], DIR_VEC[i][11], DIR_VEC[i][10:8]);
            check("R4 R6 table", DIR_VEC[i][7:0]);
        end

        for (int v = 0; v < 64; v++) begin
            @(negedge clk);
            apply(v[5], v[4], v[3], v[2:0]);
            if (!v[5]) check("R1 sweep", model(v[5], v[4], v[3], v[2:0]));
            else if (v[4] || v[3]) check("R2 sweep", model(v[5], v[4], v[3], v[2:0]));
            else check("R3 R4 sweep", model(v[5], v[4], v[3], v[2:0]));
        end

        // R5: walk select while disabled
        @(negedge clk);
        for (int s = 0; s < 8; s++) begin
            apply(1'b1, 1'b0, 1'b1, s[2:0]);
            check("R5 sel ignored", 8'hFF);
        end

        // R7: enable and select change together, no clock edge between
        @(posedge clk);
        apply(1'b1, 1'b0, 1'b0, 3'd3);
        check("R7 same step", 8'hF7);
        apply(1'b0, 1'b0, 1'b0, 3'd4);
        check("R7 same step off", 8'hFF);
        apply(1'b1, 1'b0, 1'b0, 3'd7);
        check("R3 R7 exactly one low", 8'h7F);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule